// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit device virtual address into a physical address by reading a two-level translation table from memory. A client presents the table base and the address while the walker signals idle. The walker then reads one or two table words through a simple read port that allows a single outstanding request, decodes them and returns the physical address, a page-size code and a fault flag in a one-cycle completion pulse.

A first-level word maps a 1 MB section directly or points to a second-level table. A second-level word maps a 64 KB large page or a 4 KB small page. A large page is expected to be written into 16 neighbouring second-level slots so that any address inside it finds a copy. When a walk meets an invalid word it stops, fetches nothing more, and returns the virtual address together with the level that failed.

Top module: `pt_walker`

## Requirements
- R1: During and directly after reset, `idle` is high and `mem_req` and `done` are low.
- R2: The first read goes to `{req_base[31:14], vaddr[31:20], 2'b00}`; the low 14 bits of the base are ignored.
- R3: A first-level word whose bits [1:0] are 2'b10 ends the walk with `res_addr = {word[31:20], vaddr[19:0]}`, `res_size = 2'b10` (1 MB) and `res_fault = 0`, after a single read.
- R4: A first-level word whose bits [1:0] are 2'b00 or 2'b11 ends the walk with `res_fault = 1`, `res_fault_lvl = 0`, `res_addr` equal to the virtual address and no further read.
- R5: A first-level word whose bits [1:0] are 2'b01 causes a second read at `{word[31:10], vaddr[19:12], 2'b00}`.
- R6: A second-level word whose bits [1:0] are 2'b01 ends the walk with `res_addr = {word[31:16], vaddr[15:0]}` and `res_size = 2'b01` (64 KB), for every one of the 16 slots the page covers.
- R7: A second-level word with bit 1 set (2'b10 or 2'b11) ends the walk with `res_addr = {word[31:12], vaddr[11:0]}` and `res_size = 2'b00` (4 KB).
- R8: A second-level word whose bits [1:0] are 2'b00 ends the walk with `res_fault = 1`, `res_fault_lvl = 1` and `res_addr` equal to the virtual address.
- R9: A request raised while `idle` is low is ignored: it starts no walk and does not change the result of the walk in progress.
- R10: `mem_req` with its address stays stable until `mem_ack`; every accepted request gives exactly one `done` pulse of one cycle, whatever the read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk; taken only while idle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_base | input | 32 | First-level table base, 16 KB aligned |
| idle | output | 1 | Walker can accept a request |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Byte address of the table word |
| mem_ack | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 32 | Table word returned |
| done | output | 1 | One-cycle completion pulse |
| res_addr | output | 32 | Physical address, or virtual address on fault |
| res_size | output | 2 | 00 4 KB, 01 64 KB, 10 1 MB |
| res_fault | output | 1 | Walk ended on an invalid word |
| res_fault_lvl | output | 1 | 0 first level, 1 second level |

## Verification
The assertions assume that memory raises `mem_ack` only while `mem_req` is high and for one cycle per request, and that `req_base` keeps its value while a walk runs. The bench's memory model answers only pending requests, drops its acknowledge after one cycle, and varies its latency from zero to several cycles. Requests are offered only when the walker shows idle, except in the busy-request test, where the ignored request is also checked at the result ports.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic [31:0] req_base,
  output logic        idle,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic [31:0] res_addr,
  output logic [1:0]  res_size,
  output logic        res_fault,
  output logic        res_fault_lvl
);

  typedef enum logic [1:0] {S_IDLE, S_LVL1, S_LVL2} state_t;

  state_t      st;
  logic [31:0] va_q;
  logic [17:0] base_q;
  logic [21:0] tbl2_q;

  logic unused_bits;
  assign unused_bits = ^{req_base[13:0], mem_rdata[9:2]};

  assign idle     = (st == S_IDLE);
  assign mem_req  = (st != S_IDLE);
  assign mem_addr = (st == S_LVL2) ? {tbl2_q, va_q[19:12], 2'b00}
                                   : {base_q, va_q[31:20], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      va_q          <= '0;
      base_q        <= '0;
      tbl2_q        <= '0;
      done          <= 1'b0;
      res_addr      <= '0;
      res_size      <= 2'b00;
      res_fault     <= 1'b0;
      res_fault_lvl <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          base_q <= req_base[31:14];
          st     <= S_LVL1;
        end
        S_LVL1: if (mem_ack) begin
          case (mem_rdata[1:0])
            2'b10: begin
              res_addr      <= {mem_rdata[31:20], va_q[19:0]};
              res_size      <= 2'b10;
              res_fault     <= 1'b0;
              res_fault_lvl <= 1'b0;
              done          <= 1'b1;
              st            <= S_IDLE;
            end
            2'b01: begin
              tbl2_q <= mem_rdata[31:10];
              st     <= S_LVL2;
            end
            default: begin
              res_addr      <= va_q;
              res_size      <= 2'b00;
              res_fault     <= 1'b1;
              res_fault_lvl <= 1'b0;
              done          <= 1'b1;
              st            <= S_IDLE;
            end
          endcase
        end
        S_LVL2: if (mem_ack) begin
          done          <= 1'b1;
          st            <= S_IDLE;
          res_fault_lvl <= 1'b1;
          if (mem_rdata[1]) begin
            res_addr  <= {mem_rdata[31:12], va_q[11:0]};
            res_size  <= 2'b00;
            res_fault <= 1'b0;
          end else if (mem_rdata[0]) begin
            res_addr  <= {mem_rdata[31:16], va_q[15:0]};
            res_size  <= 2'b01;
            res_fault <= 1'b0;
          end else begin
            res_addr  <= va_q;
            res_size  <= 2'b00;
            res_fault <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> $stable(va_q) || !mem_req);

  assert_fault_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_fault |-> res_addr == va_q);

  assert_section_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && !res_fault && res_size == 2'b10 |-> res_addr[19:0] == va_q[19:0]);

  assert_size_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !res_fault |-> res_size != 2'b11);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle);

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_base = '0;
  logic        idle, mem_req, done, res_fault, res_fault_lvl;
  logic [31:0] mem_addr, res_addr;
  logic [1:0]  res_size;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int total = 0;
  int bad = 0;
  int lat = 0;
  int cnt = 0;
  int cycles = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] log_q [$];
  localparam logic [31:0] BASE = 32'h0010_0000;

  logic [31:0] g_addr;
  logic [1:0]  g_size;
  logic        g_fault, g_lvl, g_ok;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_base(req_base), .idle(idle), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .res_addr(res_addr),
    .res_size(res_size), .res_fault(res_fault), .res_fault_lvl(res_fault_lvl));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_ack = 1'b0; cnt = 0;
      end else if (mem_ack) begin
        mem_ack = 1'b0; cnt = 0;
      end else if (mem_req) begin
        if (cnt >= lat) begin
          mem_ack   = 1'b1;
          mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
          log_q.push_back(mem_addr);
        end else cnt++;
      end
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic ref_walk(input logic [31:0] base, input logic [31:0] va,
                          output logic [31:0] pa, output logic [1:0] sz,
                          output logic flt, output logic lvl);
    logic [31:0] e1, e2;
    e1 = rd({base[31:14], va[31:20], 2'b00});
    pa = va; sz = 2'b00; flt = 1'b1; lvl = 1'b0;
    if (e1[1:0] == 2'b10) begin
      pa = {e1[31:20], 20'h0} + {12'h0, va[19:0]}; sz = 2'b10; flt = 1'b0;
    end else if (e1[1:0] == 2'b01) begin
      e2 = rd({e1[31:10], 10'h0} + {22'h0, va[19:12], 2'b00});
      lvl = 1'b1;
      if (e2[1]) begin
        pa = {e2[31:12], 12'h0} + {20'h0, va[11:0]}; sz = 2'b00; flt = 1'b0;
      end else if (e2[0]) begin
        pa = {e2[31:16], 16'h0} + {16'h0, va[15:0]}; sz = 2'b01; flt = 1'b0;
      end
    end
  endtask

  task automatic run(input logic [31:0] va);
    int n;
    @(negedge clk);
    while (!idle) @(negedge clk);
    log_q.delete();
    req_vaddr = va; req_base = BASE | 32'h0000_2A5C; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 300) begin @(negedge clk); n++; end
    g_ok = done; g_addr = res_addr; g_size = res_size;
    g_fault = res_fault; g_lvl = res_fault_lvl;
  endtask

  task automatic walk_and_check(input string rq, input logic [31:0] va);
    logic [31:0] pa; logic [1:0] sz; logic flt, lvl;
    run(va);
    ref_walk(BASE, va, pa, sz, flt, lvl);
    chk({rq, " done"}, {31'h0, g_ok}, 32'h1);
    chk({rq, " addr"}, g_addr, pa);
    chk({rq, " fault"}, {31'h0, g_fault}, {31'h0, flt});
    if (flt) chk({rq, " level"}, {31'h0, g_lvl}, {31'h0, lvl});
    else     chk({rq, " size"}, {30'h0, g_size}, {30'h0, sz});
  endtask

  task automatic t_reset;
    chk("R1 idle", {31'h0, idle}, 32'h1);
    chk("R1 mem_req", {31'h0, mem_req}, 32'h0);
    chk("R1 done", {31'h0, done}, 32'h0);
  endtask

  task automatic t_section;
    lat = 0;
    walk_and_check("R3 section", 32'h1234_5678);
    chk("R3 reads", log_q.size(), 1);
    chk("R2 l1 addr", log_q[0], BASE + 32'h123 * 4);
    chk("R3 value", g_addr, 32'hABC4_5678);
    lat = 3;
    walk_and_check("R3 section slow", 32'h123F_FFFF);
  endtask

  task automatic t_l1_fault;
    lat = 1;
    walk_and_check("R4 type11", 32'h3000_1234);
    chk("R4 no l2 read 11", log_q.size(), 1);
    walk_and_check("R4 type00", 32'h3010_0000);
    chk("R4 no l2 read 00", log_q.size(), 1);
    chk("R4 level", {31'h0, g_lvl}, 32'h0);
  endtask

  task automatic t_large;
    lat = 0;
    for (int i = 0; i < 16; i++) begin
      walk_and_check("R6 large", 32'h2001_0000 | (i << 12) | 32'h0000_0ABC);
      chk("R6 value", g_addr, 32'h7777_0ABC | (i << 12));
    end
    chk("R5 l2 addr", log_q[1], 32'h0020_0400 + 32'h1F * 4);
  endtask

  task automatic t_small;
    lat = 2;
    walk_and_check("R7 small10", 32'h2000_5321);
    chk("R7 value10", g_addr, 32'h5555_5321);
    chk("R5 l2 addr", log_q[1], 32'h0020_0414);
    walk_and_check("R7 small11", 32'h2000_6FFF);
    chk("R7 value11", g_addr, 32'h6666_6FFF);
  endtask

  task automatic t_l2_fault;
    lat = 0;
    walk_and_check("R8 l2 fault", 32'h2000_7004);
    chk("R8 level", {31'h0, g_lvl}, 32'h1);
    chk("R8 reads", log_q.size(), 2);
  endtask

  task automatic t_busy;
    int n, pulses;
    lat = 4;
    @(negedge clk);
    while (!idle) @(negedge clk);
    log_q.delete();
    req_vaddr = 32'h1230_0001; req_valid = 1'b1;
    @(negedge clk);
    req_vaddr = 32'h2000_5000;
    for (int k = 0; k < 3; k++) @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 300) begin @(negedge clk); n++; end
    chk("R9 first result", res_addr, 32'hABC0_0001);
    chk("R9 size", {30'h0, res_size}, 32'h2);
    pulses = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    chk("R9 no extra walk", pulses, 0);
    chk("R9 reads", log_q.size(), 1);
    chk("R10 idle after", {31'h0, idle}, 32'h1);
  endtask

  initial begin
    mem[BASE + 32'h123 * 4] = 32'hABC0_0002;
    mem[BASE + 32'h200 * 4] = 32'h0020_0401;
    mem[BASE + 32'h300 * 4] = 32'h0000_0003;
    for (int i = 16; i < 32; i++) mem[32'h0020_0400 + i * 4] = 32'h7777_0001;
    mem[32'h0020_0414] = 32'h5555_5002;
    mem[32'h0020_0418] = 32'h6666_6003;
    mem[32'h0020_041C] = 32'h0000_0000;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_section;
    t_l1_fault;
    t_large;
    t_small;
    t_l2_fault;
    t_busy;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule